// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Model

This block is a synthesizable, scaled-down behavioural model of a synchronous burst SRAM. It has a read path with two register stages. The default array holds 64 words, and each word is four bytes. An access opens with one of two start strobes, which load an external address into an internal burst sequencer. Later cycles with neither strobe low continue the burst from that address. The advance input steps the sequencer through a four-beat group, in either linear or interleaved order.

Writes can be global, covering the whole word, or can cover selected bytes. Reads return data through a registered output stage. A valid flag stands in for the tri-state state of the output bus: when the flag is low, the data bus reads as zero. The output is switched off by three things: an inactive output enable, a deselected device, or any byte enable sampled low on a non-processor edge.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted and immediately after it, `rvalid_o` is 0 and `rdata_o` is 0. Every array word resets to zero.
- R2: A read access accepted on rising edge k loads `rdata_o`/`rvalid_o` on edge k+1. These outputs are visible after that edge.
- R3: An edge with `cpu_stb_ni` low and all chip enables active starts a read at `addr_i`. This holds whatever `ctl_stb_ni`, `gwr_ni`, `bwr_ni` and `be_ni` are, and nothing is written.
- R4: On a write cycle with `gwr_ni` low, all four bytes of the word are written from `wdata_i`, whatever `bwr_ni` and `be_ni` are.
- R5: With `gwr_ni` high, byte b (bits 8b+7:8b) is written only when `bwr_ni` is low and `be_ni[b]` is low. A cycle that writes no byte is a read.
- R6: On an edge that samples `cpu_stb_ni` low, `be_ni` neither writes nor disables the output.
- R7: On an edge with `cpu_stb_ni` high and any `be_ni` bit low, the output register loads `rvalid_o`=0 and `rdata_o`=0. This happens even with `oe_ni` low.
- R8: An edge with `ctl_stb_ni` low, `cpu_stb_ni` high and chip enables active starts an access at `addr_i`. The write controls sampled on that same edge decide whether it writes (per R4/R5) or reads.
- R9: On a continuation edge (both strobes high, burst open), the access goes to the next burst address if `adv_ni` is low. If `adv_ni` is high, it goes to the same address again. This applies to both reads and writes.
- R10: The burst counter is two bits wide and starts at 0. With `lin_i`=1 the low two address bits are start plus count, modulo 4. With `lin_i`=0 they are start XOR count. The upper bits stay fixed, and the sequence wraps after four beats.
- R11: When `oe_ni` is high on the edge that loads the output register, `rvalid_o` is 0 and `rdata_o` is 0.
- R12: An edge with either strobe low while the chip enables are inactive deselects the device and closes the burst. Continuation edges then make no access until a new start strobe.
- R13: The chip enables are active only when `cs_ni`=0, `cs_i`=1 and `cs2_ni`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address loaded by a start strobe |
| cpu_stb_ni | input | 1 | Processor start strobe, active low (read start) |
| ctl_stb_ni | input | 1 | Controller start strobe, active low (read or write start) |
| adv_ni | input | 1 | Burst advance, active low |
| cs_ni | input | 1 | Master chip enable, active low |
| cs_i | input | 1 | Chip enable, active high |
| cs2_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| gwr_ni | input | 1 | Global write, active low |
| bwr_ni | input | 1 | Byte write enable, active low |
| be_ni | input | NBYTES | Per-byte write selects, active low |
| lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data, zero when not valid |
| rvalid_o | output | 1 | Output driven (low models a tri-stated bus) |

## Verification
A read sampled on edge k shows up on the ports only after edge k+1. The valid flag for that read is decided by `oe_ni`, `cpu_stb_ni` and `be_ni` as sampled on edge k+1, not on edge k. The reference model in the bench updates its state at every rising edge. It first works out the output register from the read held over from the previous edge, then processes the current edge's access. The bench compares that result to the ports at the following falling edge. Writes and ignored controls are observed by reading the affected words back through later bursts.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, cnt_use, off;

  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign cnt_use = step_i ? cnt_nxt : cnt_q;

  generate
    if (ADDR_W > CNT_W) begin : g_hi
      assign addr_o = load_i ? addr_i : {base_q[ADDR_W-1:CNT_W], off};
    end else begin : g_lo
      assign addr_o = load_i ? addr_i : off[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    if (lin_i) off = base_q[CNT_W-1:0] + cnt_use;
    else       off = base_q[CNT_W-1:0] ^ cnt_use;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      cnt_q  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/byte_ctl.sv
module byte_ctl #(
  parameter int NBYTES = 4
) (
  input  logic              cpu_edge_i,  // processor strobe low on this edge
  input  logic              gwr_ni,
  input  logic              bwr_ni,
  input  logic [NBYTES-1:0] be_ni,
  output logic [NBYTES-1:0] wmask_o,
  output logic              kill_o
);
  always_comb begin
    if (cpu_edge_i)   wmask_o = '0;
    else if (!gwr_ni) wmask_o = '1;
    else if (!bwr_ni) wmask_o = ~be_ni;
    else              wmask_o = '0;
  end

  assign kill_o = !cpu_edge_i && (be_ni != '1);
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NBYTES-1:0]        we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i[b]) begin
        mem_q[waddr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
      end
    end

    assign rdata_o[b*BYTE_W +: BYTE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_stb_ni,
  input  logic              ctl_stb_ni,
  input  logic              adv_ni,
  input  logic              cs_ni,
  input  logic              cs_i,
  input  logic              cs2_ni,
  input  logic              oe_ni,
  input  logic              gwr_ni,
  input  logic              bwr_ni,
  input  logic [NBYTES-1:0] be_ni,
  input  logic              lin_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic              sel, strobe, cpu_start, ctl_start, cont, load, step;
  logic              active_q, rd_q, kill, out_en;
  logic [NBYTES-1:0] wmask, we;
  logic [ADDR_W-1:0] acc_addr, rd_addr_q;
  logic [DATA_W-1:0] arr_rdata;
  acc_e              acc;

  assign sel       = !cs_ni && cs_i && !cs2_ni;
  assign strobe    = !cpu_stb_ni || !ctl_stb_ni;
  assign cpu_start = !cpu_stb_ni && sel;
  assign ctl_start = cpu_stb_ni && !ctl_stb_ni && sel;
  assign cont      = !strobe && active_q;
  assign load      = cpu_start || ctl_start;
  assign step      = cont && !adv_ni;

  burst_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .lin_i  (lin_i),
    .addr_i (addr_i),
    .addr_o (acc_addr)
  );

  byte_ctl #(.NBYTES(NBYTES)) u_bctl (
    .cpu_edge_i (!cpu_stb_ni),
    .gwr_ni     (gwr_ni),
    .bwr_ni     (bwr_ni),
    .be_ni      (be_ni),
    .wmask_o    (wmask),
    .kill_o     (kill)
  );

  always_comb begin
    if (cpu_start)              acc = ACC_READ;
    else if (ctl_start || cont) acc = (wmask != '0) ? ACC_WRITE : ACC_READ;
    else                        acc = ACC_NONE;
  end

  assign we = (acc == ACC_WRITE) ? wmask : '0;

  sram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (acc_addr),
    .wdata_i (wdata_i),
    .raddr_i (rd_addr_q),
    .rdata_o (arr_rdata)
  );

  // burst state: opened by a start, closed by a strobe while deselected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= 1'b0;
    else if (load)   active_q <= 1'b1;
    else if (strobe) active_q <= 1'b0;
  end

  // stage 1: address register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_q      <= (acc == ACC_READ);
      rd_addr_q <= acc_addr;
    end
  end

  // stage 2: output register
  assign out_en = rd_q && !oe_ni && !kill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= out_en;
      rdata_o  <= out_en ? arr_rdata : '0;
    end
  end
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int NBYTES = 4,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_stb_ni,
  input logic              ctl_stb_ni,
  input logic              cs_ni,
  input logic              cs_i,
  input logic              cs2_ni,
  input logic              oe_ni,
  input logic [NBYTES-1:0] be_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o
);
  logic en;
  assign en = !cs_ni && cs_i && !cs2_ni;

  p_oe_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(!oe_ni));

  p_off_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));

  p_be_kill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_stb_ni && (be_ni != '1)) |=> !rvalid_o);

  p_desel_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && (!cpu_stb_ni || !ctl_stb_ni)) |-> ##2 !rvalid_o);

  p_cpu_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_stb_ni && en) ##1 (!oe_ni && ((be_ni == '1) || !cpu_stb_ni)) |=> rvalid_o);
endmodule

bind burst_sram burst_sram_chk #(.NBYTES(NBYTES), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_stb_ni (cpu_stb_ni),
  .ctl_stb_ni (ctl_stb_ni),
  .cs_ni      (cs_ni),
  .cs_i       (cs_i),
  .cs2_ni     (cs2_ni),
  .oe_ni      (oe_ni),
  .be_ni      (be_ni),
  .rdata_o    (rdata_o),
  .rvalid_o   (rvalid_o)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
  logic        cs_n = 1'b0, cs = 1'b1, cs2_n = 1'b0, oe_n = 1'b0;
  logic        gw_n = 1'b1, bw_n = 1'b1, lin = 1'b1;
  logic [3:0]  be_n = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string req = "R1";

  always #5 clk = ~clk;

  burst_sram u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .cpu_stb_ni(cpu_n),
    .ctl_stb_ni(ctl_n), .adv_ni(adv_n), .cs_ni(cs_n), .cs_i(cs),
    .cs2_ni(cs2_n), .oe_ni(oe_n), .gwr_ni(gw_n), .bwr_ni(bw_n),
    .be_ni(be_n), .lin_i(lin), .wdata_i(wdata), .rdata_o(rdata),
    .rvalid_o(rvalid)
  );

  // reference model
  logic [31:0] mem_m [64];
  bit          pend_v, exp_v, act, en_m, kill_m;
  logic [31:0] pend_d, exp_d;
  logic [5:0]  base_m;
  int          cnt_m;

  function automatic logic [5:0] burst_addr();
    logic [1:0] lo;
    lo = lin ? 2'((int'(base_m[1:0]) + cnt_m) % 4) : (base_m[1:0] ^ 2'(cnt_m));
    return {base_m[5:2], lo};
  endfunction

  task automatic access(input logic [5:0] a);
    logic [3:0] m;
    m = !gw_n ? 4'hF : (!bw_n ? ~be_n : 4'h0);
    if (m != 4'h0) begin
      for (int b = 0; b < 4; b++)
        if (m[b]) mem_m[a][b*8 +: 8] = wdata[b*8 +: 8];
    end else begin
      pend_v = 1'b1;
      pend_d = mem_m[a];
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem_m[i] = '0;
      pend_v = 0; exp_v = 0; exp_d = '0; act = 0; base_m = '0; cnt_m = 0;
    end else begin
      kill_m = cpu_n && (be_n != 4'hF);
      exp_v  = pend_v && !oe_n && !kill_m;
      exp_d  = exp_v ? pend_d : '0;
      en_m   = !cs_n && cs && !cs2_n;
      pend_v = 1'b0;
      if ((!cpu_n || !ctl_n) && !en_m) act = 1'b0;
      else if (!cpu_n) begin
        base_m = addr; cnt_m = 0; act = 1'b1;
        pend_v = 1'b1; pend_d = mem_m[addr];
      end else if (!ctl_n) begin
        base_m = addr; cnt_m = 0; act = 1'b1;
        access(addr);
      end else if (act) begin
        if (!adv_n) cnt_m = (cnt_m + 1) % 4;
        access(burst_addr());
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rvalid !== exp_v || rdata !== exp_d) begin
        errors++;
        $display("FAIL %s: rvalid/rdata actual %0b/%h expected %0b/%h",
                 req, rvalid, rdata, exp_v, exp_d);
      end
    end
  end

  task automatic nxt();
    @(negedge clk);
    cpu_n = 1; ctl_n = 1; adv_n = 1; gw_n = 1; bw_n = 1; be_n = 4'hF;
    oe_n = 0; cs_n = 0; cs = 1; cs2_n = 0; wdata = '0;
  endtask

  task automatic cpu_rd(input logic [5:0] a);
    nxt(); cpu_n = 0; addr = a;
  endtask

  task automatic ctl_wr(input logic [5:0] a, input logic [31:0] d,
                        input logic g, input logic bw, input logic [3:0] be);
    nxt(); ctl_n = 0; addr = a; wdata = d; gw_n = g; bw_n = bw; be_n = be;
  endtask

  task automatic beat(input logic adv, input logic g, input logic [31:0] d);
    nxt(); adv_n = adv; gw_n = g; wdata = d;
  endtask

  task automatic flush();
    repeat (3) nxt();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    checks++;
    if (rvalid !== 1'b0 || rdata !== '0) begin
      errors++;
      $display("FAIL R1: in reset rvalid/rdata actual %0b/%h expected 0/0", rvalid, rdata);
    end
    rst_n = 1'b1;
    cpu_rd(6'd5); flush();

    req = "R4"; ctl_wr(6'd3, 32'hA1B2C3D4, 1'b0, 1'b1, 4'h0); flush();
    cpu_rd(6'd3); flush();
    req = "R5"; ctl_wr(6'd3, 32'h11223344, 1'b1, 1'b0, 4'b1010); flush();
    ctl_wr(6'd3, 32'hFFFFFFFF, 1'b1, 1'b1, 4'h0); flush();
    cpu_rd(6'd3); flush();

    req = "R3";
    nxt(); cpu_n = 0; ctl_n = 0; gw_n = 0; wdata = 32'hDEADBEEF; addr = 6'd3; flush();
    req = "R6";
    nxt(); cpu_n = 0; bw_n = 0; be_n = 4'h0; wdata = 32'h0; addr = 6'd3;
    nxt(); cpu_n = 0; bw_n = 0; be_n = 4'h0; addr = 6'd4; flush();
    cpu_rd(6'd3); flush();

    req = "R8"; ctl_wr(6'd3, 32'h0, 1'b1, 1'b1, 4'hF); flush();

    req = "R9"; lin = 1'b1;
    ctl_wr(6'd9, 32'h90000001, 1'b0, 1'b1, 4'hF);
    beat(1'b0, 1'b0, 32'h90000002);
    beat(1'b0, 1'b0, 32'h90000003);
    beat(1'b1, 1'b0, 32'h90000004);
    beat(1'b0, 1'b0, 32'h90000005); flush();
    cpu_rd(6'd9); beat(1'b0, 1'b1, '0); beat(1'b0, 1'b1, '0);
    beat(1'b1, 1'b1, '0); beat(1'b0, 1'b1, '0); flush();

    req = "R10"; lin = 1'b0;
    ctl_wr(6'd22, 32'h16000000, 1'b0, 1'b1, 4'hF);
    for (int i = 1; i < 5; i++) beat(1'b0, 1'b0, 32'h16000000 + i); flush();
    cpu_rd(6'd23);
    for (int i = 0; i < 5; i++) beat(1'b0, 1'b1, '0); flush();
    lin = 1'b1; cpu_rd(6'd22);
    for (int i = 0; i < 5; i++) beat(1'b0, 1'b1, '0); flush();

    req = "R7";
    cpu_rd(6'd9);
    nxt(); adv_n = 0; be_n = 4'b1110;
    beat(1'b0, 1'b1, '0); flush();

    req = "R11";
    cpu_rd(6'd10); nxt(); oe_n = 1; flush();

    req = "R12";
    cpu_rd(6'd8); beat(1'b0, 1'b1, '0);
    nxt(); ctl_n = 0; cs = 0; addr = 6'd0;
    beat(1'b0, 1'b1, '0); beat(1'b0, 1'b1, '0); flush();

    req = "R13";
    nxt(); cpu_n = 0; cs2_n = 1; addr = 6'd3; flush();
    nxt(); ctl_n = 0; cs_n = 1; addr = 6'd3; flush();
    cpu_rd(6'd3); flush();

    req = "R2";
    for (int i = 0; i < 4000; i++) begin
      nxt();
      cpu_n = ($urandom % 8) == 0;
      cpu_n = !cpu_n;
      ctl_n = ($urandom % 6) != 0;
      adv_n = $urandom % 2;
      gw_n  = ($urandom % 5) != 0;
      bw_n  = $urandom % 2;
      be_n  = ($urandom % 3 == 0) ? 4'($urandom) : 4'hF;
      oe_n  = ($urandom % 8) == 0;
      cs_n  = ($urandom % 12) == 0;
      cs    = ($urandom % 12) != 0;
      cs2_n = ($urandom % 12) == 0;
      lin   = (i % 500) < 250;
      addr  = 6'($urandom);
      wdata = $urandom;
    end
    flush();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule